// File: doc/BRIEF.md
# Dual-Width Cycle Counter

This block keeps a 64-bit count of clock cycles for a performance-monitoring unit. It advances only in cycles where an outside mode filter asserts its enable. Software reaches the count through one access port. A narrow access carries the low 32-bit word. A wide access carries both 32-bit words in a single operation, with the upper word on its own data lane.

Two control inputs change how the count advances. A divider mode makes it step once per 64 enabled cycles. A long-count mode moves the overflow point from the low word to the full 64-bit value. A clear pulse from the control logic zeroes the count. When a restricted-user flag is active, the access port can be narrowed: reads return zeros and writes are dropped quietly, with no fault raised.

Top module: `cycle_counter`

## Requirements
- R1: With the reset-to-zero parameter set, the count reads as zero after reset and the overflow pulse is low.
- R2: The count rises by exactly one for each clock edge at which `countEn` is high and divider mode is off, and it holds while `countEn` is low.
- R3: With `divEn` high, the count rises by one on the 64th enabled edge after a clear, and not before.
- R4: A narrow write (`accWide`=0) loads bits [31:0] from `wrLo` and leaves bits [63:32] unchanged.
- R5: A wide write (`accWide`=1) loads bits [63:32] from `wrHi` and bits [31:0] from `wrLo` at the same edge.
- R6: A read returns bits [31:0] on `rdLo`. A wide read also returns bits [63:32] on `rdHi`. A narrow read drives `rdHi` to zero.
- R7: `clearPulse` zeroes the whole count at the next edge and takes priority over a write and an increment in the same cycle.
- R8: A permitted write in the same cycle as an increment loads the written value, with no increment added.
- R9: With `longMode` low, `ovfPulse` is high for exactly one cycle after an increment carries out of bit 31.
- R10: With `longMode` high, a carry out of bit 31 raises no pulse. A carry out of bit 63 raises `ovfPulse` for one cycle.
- R11: With `userRestrict` high and `userAccessOk` low, reads return zero on both data words.
- R12: With `userRestrict` high, a write is ignored when `userAccessOk` is low or `userReadOnly` is high. When access is allowed and not read-only, the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| countEn | input | 1 | Increment permitted by the external mode filter |
| clearPulse | input | 1 | Zero the whole count |
| divEn | input | 1 | Step once per 64 enabled cycles |
| longMode | input | 1 | Overflow on bit 63 carry instead of bit 31 carry |
| accValid | input | 1 | Access strobe |
| accWrite | input | 1 | 1 for write, 0 for read |
| accWide | input | 1 | 1 for a 64-bit access, 0 for a 32-bit access |
| wrLo | input | 32 | Write data for bits [31:0] |
| wrHi | input | 32 | Write data for bits [63:32] (wide writes only) |
| userRestrict | input | 1 | Restricted-user access path active |
| userAccessOk | input | 1 | Per-counter user access permitted |
| userReadOnly | input | 1 | User writes forbidden |
| rdLo | output | 32 | Read data for bits [31:0] |
| rdHi | output | 32 | Read data for bits [63:32] |
| ovfPulse | output | 1 | One-cycle overflow indication |

## Verification
A vector table alternates wide and narrow writes, each followed by a wide readback. This shows whether a narrow write really keeps the upper word, and whether the two lanes of a wide write could be swapped. Directed runs then count with the divider off and on, which separates a count of one per cycle from one per 64 cycles and checks for an off-by-one at the 63/64 boundary. Stacked clear, write and increment in one cycle expose the priority order. Carries placed at bit 31 in both overflow modes separate short-mode overflow from long-mode overflow. Each combination of the three user-restriction inputs is paired with a readback, which shows whether a blocked access leaked through.

// File: rtl/cycle_counter_pkg.sv
package cycle_counter_pkg;
  // strobes sent from control to datapath for one cycle
  typedef struct packed {
    logic clr;    // zero the whole count
    logic ldLo;   // load low word
    logic ldHi;   // load high word
    logic inc;    // advance by one
    logic rdLo;   // drive low read lane
    logic rdHi;   // drive high read lane
  } cntStrobes_t;
endpackage

// File: rtl/cycle_counter_ctrl.sv
module cycle_counter_ctrl
  import cycle_counter_pkg::*;
#(
  parameter int PRE_W = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        countEn,
  input  logic        clearPulse,
  input  logic        divEn,
  input  logic        accValid,
  input  logic        accWrite,
  input  logic        accWide,
  input  logic        userRestrict,
  input  logic        userAccessOk,
  input  logic        userReadOnly,
  output cntStrobes_t strb
);
  logic [PRE_W-1:0] presQ;
  logic             presWrap;
  logic             rdBlocked;
  logic             wrBlocked;

  assign presWrap = &presQ;

  // prescaler only runs in divider mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      presQ <= '0;
    else if (clearPulse)
      presQ <= '0;
    else if (countEn && divEn)
      presQ <= presQ + 1'b1;
  end

  assign rdBlocked = userRestrict && !userAccessOk;
  assign wrBlocked = userRestrict && (!userAccessOk || userReadOnly);

  always_comb begin
    strb.clr  = clearPulse;
    strb.ldLo = accValid && accWrite && !wrBlocked;
    strb.ldHi = accValid && accWrite && !wrBlocked && accWide;
    strb.inc  = countEn && (!divEn || presWrap);
    strb.rdLo = accValid && !accWrite && !rdBlocked;
    strb.rdHi = accValid && !accWrite && !rdBlocked && accWide;
  end
endmodule

// File: rtl/cycle_counter_dp.sv
module cycle_counter_dp
  import cycle_counter_pkg::*;
#(
  parameter int HALF_W        = 32,
  parameter bit ZERO_ON_RESET = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  cntStrobes_t         strb,
  input  logic                longMode,
  input  logic [HALF_W-1:0]   wrLo,
  input  logic [HALF_W-1:0]   wrHi,
  output logic [HALF_W-1:0]   rdLo,
  output logic [HALF_W-1:0]   rdHi,
  output logic [2*HALF_W-1:0] cntVal,
  output logic                ovfPulse
);
  localparam int CNT_W = 2 * HALF_W;

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntD;
  logic             ovfD;
  logic             ovfQ;
  logic             incTaken;

  // priority: clear, then write, then increment
  assign incTaken = strb.inc && !strb.clr && !strb.ldLo;

  always_comb begin
    cntD = cntQ;
    if (strb.clr)
      cntD = '0;
    else if (strb.ldLo)
      cntD = {(strb.ldHi ? wrHi : cntQ[CNT_W-1:HALF_W]), wrLo};
    else if (strb.inc)
      cntD = cntQ + 1'b1;
  end

  assign ovfD = incTaken && (longMode ? (&cntQ) : (&cntQ[HALF_W-1:0]));

  generate
    if (ZERO_ON_RESET) begin : g_rstCnt
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) cntQ <= '0;
        else       cntQ <= cntD;
      end
    end else begin : g_freeCnt
      always_ff @(posedge clk) begin
        cntQ <= cntD;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ovfQ <= 1'b0;
    else       ovfQ <= ovfD;
  end

  assign rdLo     = strb.rdLo ? cntQ[HALF_W-1:0]     : '0;
  assign rdHi     = strb.rdHi ? cntQ[CNT_W-1:HALF_W] : '0;
  assign cntVal   = cntQ;
  assign ovfPulse = ovfQ;
endmodule

// File: rtl/cycle_counter.sv
module cycle_counter
  import cycle_counter_pkg::*;
#(
  parameter int HALF_W        = 32,
  parameter int PRE_W         = 6,
  parameter bit ZERO_ON_RESET = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              countEn,
  input  logic              clearPulse,
  input  logic              divEn,
  input  logic              longMode,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic              accWide,
  input  logic [HALF_W-1:0] wrLo,
  input  logic [HALF_W-1:0] wrHi,
  input  logic              userRestrict,
  input  logic              userAccessOk,
  input  logic              userReadOnly,
  output logic [HALF_W-1:0] rdLo,
  output logic [HALF_W-1:0] rdHi,
  output logic              ovfPulse
);
  cntStrobes_t         strb;
  logic [2*HALF_W-1:0] cntVal;

  cycle_counter_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .countEn(countEn), .clearPulse(clearPulse),
    .divEn(divEn), .accValid(accValid), .accWrite(accWrite), .accWide(accWide),
    .userRestrict(userRestrict), .userAccessOk(userAccessOk),
    .userReadOnly(userReadOnly), .strb(strb)
  );

  cycle_counter_dp #(.HALF_W(HALF_W), .ZERO_ON_RESET(ZERO_ON_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .longMode(longMode),
    .wrLo(wrLo), .wrHi(wrHi), .rdLo(rdLo), .rdHi(rdHi),
    .cntVal(cntVal), .ovfPulse(ovfPulse)
  );
endmodule

// File: rtl/cycle_counter_chk.sv
module cycle_counter_chk #(
  parameter int HALF_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                countEn,
  input logic                clearPulse,
  input logic                longMode,
  input logic                accValid,
  input logic                accWrite,
  input logic                accWide,
  input logic [HALF_W-1:0]   wrLo,
  input logic                userRestrict,
  input logic                userAccessOk,
  input logic                userReadOnly,
  input logic [HALF_W-1:0]   rdLo,
  input logic [HALF_W-1:0]   rdHi,
  input logic                ovfPulse,
  input logic [2*HALF_W-1:0] cntVal
);
  localparam int CNT_W = 2 * HALF_W;

  logic wrOk;
  assign wrOk = accValid && accWrite && !(userRestrict && (!userAccessOk || userReadOnly));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!countEn && !clearPulse && !(accValid && accWrite)) |=> $stable(cntVal));

  a_r4_narrow_keeps_high: assert property (@(posedge clk) disable iff (!rstN)
    (wrOk && !accWide && !clearPulse) |=>
      (cntVal[CNT_W-1:HALF_W] == $past(cntVal[CNT_W-1:HALF_W]) && cntVal[HALF_W-1:0] == $past(wrLo)));

  a_r6_narrow_read_high_zero: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accWrite && !accWide) |-> (rdHi == '0));

  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    clearPulse |=> (cntVal == '0));

  a_r9_ovf_low_wrapped: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> (cntVal[HALF_W-1:0] == '0));

  a_r10_long_full_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (ovfPulse && $past(longMode)) |-> (cntVal == '0));

  a_r11_restricted_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (userRestrict && !userAccessOk) |-> (rdLo == '0 && rdHi == '0));

  a_r12_readonly_write_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accWrite && userRestrict && userReadOnly && !clearPulse && !countEn)
      |=> $stable(cntVal));
endmodule

bind cycle_counter cycle_counter_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rstN(rstN), .countEn(countEn), .clearPulse(clearPulse),
  .longMode(longMode), .accValid(accValid), .accWrite(accWrite),
  .accWide(accWide), .wrLo(wrLo), .userRestrict(userRestrict),
  .userAccessOk(userAccessOk), .userReadOnly(userReadOnly),
  .rdLo(rdLo), .rdHi(rdHi), .ovfPulse(ovfPulse), .cntVal(cntVal)
);

// File: tb/sim_cycle_counter.sv
`timescale 1ns/1ps
module sim_cycle_counter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        countEn = 0, clearPulse = 0, divEn = 0, longMode = 0;
  logic        accValid = 0, accWrite = 0, accWide = 0;
  logic [31:0] wrLo = '0, wrHi = '0;
  logic        userRestrict = 0, userAccessOk = 0, userReadOnly = 0;
  logic [31:0] rdLo, rdHi;
  logic        ovfPulse;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  always #10 clk = ~clk;  // 50 MHz

  cycle_counter #(.HALF_W(32), .PRE_W(6), .ZERO_ON_RESET(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .countEn(countEn), .clearPulse(clearPulse),
    .divEn(divEn), .longMode(longMode), .accValid(accValid), .accWrite(accWrite),
    .accWide(accWide), .wrLo(wrLo), .wrHi(wrHi), .userRestrict(userRestrict),
    .userAccessOk(userAccessOk), .userReadOnly(userReadOnly),
    .rdLo(rdLo), .rdHi(rdHi), .ovfPulse(ovfPulse)
  );

  typedef struct packed {
    logic        wide;
    logic [31:0] hi;
    logic [31:0] lo;
    logic [31:0] expHi;
    logic [31:0] expLo;
  } vec_t;

  // R4 / R5 vectors: write then wide readback, counting stopped
  localparam vec_t VECS [6] = '{
    '{1'b1, 32'h1111_1111, 32'h2222_2222, 32'h1111_1111, 32'h2222_2222},
    '{1'b0, 32'hDEAD_BEEF, 32'hAAAA_AAAA, 32'h1111_1111, 32'hAAAA_AAAA},
    '{1'b1, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    '{1'b0, 32'h5555_5555, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF},
    '{1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000},
    '{1'b0, 32'h0000_0000, 32'h1234_5678, 32'hFFFF_FFFF, 32'h1234_5678}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic doWrite(input logic wide, input logic [31:0] hi, input logic [31:0] lo);
    accValid = 1; accWrite = 1; accWide = wide; wrHi = hi; wrLo = lo;
    @(negedge clk);
    accValid = 0; accWrite = 0;
  endtask

  task automatic readChk(input logic wide, input logic [31:0] eHi, input logic [31:0] eLo, input string req);
    accValid = 1; accWrite = 0; accWide = wide;
    #2;
    check({rdHi, rdLo} == {eHi, eLo}, req, {rdHi, rdLo}, {eHi, eLo});
    @(negedge clk);
    accValid = 0;
  endtask

  task automatic pulseClear();
    clearPulse = 1;
    @(negedge clk);
    clearPulse = 0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(ovfPulse == 1'b0, "R1 ovf", {63'd0, ovfPulse}, 64'd0);
    readChk(1, 32'h0, 32'h0, "R1 reset value");

    // R4 R5 vector table
    for (int i = 0; i < 6; i++) begin
      doWrite(VECS[i].wide, VECS[i].hi, VECS[i].lo);
      readChk(1, VECS[i].expHi, VECS[i].expLo, VECS[i].wide ? "R5 wide write" : "R4 narrow write");
    end

    // R6 narrow read drives high lane to zero
    readChk(0, 32'h0, 32'h1234_5678, "R6 narrow read");

    // R2 plain counting and hold
    doWrite(1, 32'h0, 32'h0);
    countEn = 1;
    repeat (10) @(negedge clk);
    countEn = 0;
    readChk(1, 32'h0, 32'd10, "R2 ten cycles");
    repeat (5) @(negedge clk);
    readChk(1, 32'h0, 32'd10, "R2 hold");

    // R3 divider
    pulseClear();
    divEn = 1; countEn = 1;
    repeat (63) @(negedge clk);
    countEn = 0;
    readChk(1, 32'h0, 32'd0, "R3 before 64th");
    countEn = 1;
    @(negedge clk);
    countEn = 0;
    readChk(1, 32'h0, 32'd1, "R3 on 64th");
    divEn = 0;

    // R7 clear beats write and increment
    doWrite(1, 32'h9, 32'h9);
    countEn = 1; clearPulse = 1;
    doWrite(1, 32'h7, 32'h7);
    countEn = 0; clearPulse = 0;
    readChk(1, 32'h0, 32'h0, "R7 clear priority");

    // R8 write beats increment
    countEn = 1;
    doWrite(1, 32'h100, 32'h5);
    countEn = 0;
    readChk(1, 32'h100, 32'h5, "R8 write priority");

    // R9 short-mode overflow
    doWrite(1, 32'h0, 32'hFFFF_FFFE);
    countEn = 1;
    @(negedge clk);
    #1 check(ovfPulse == 1'b0, "R9 no early ovf", {63'd0, ovfPulse}, 64'd0);
    @(negedge clk);
    countEn = 0;
    #1 check(ovfPulse == 1'b1, "R9 ovf on bit31 carry", {63'd0, ovfPulse}, 64'd1);
    readChk(1, 32'h1, 32'h0, "R9 value after carry");
    #1 check(ovfPulse == 1'b0, "R9 single cycle", {63'd0, ovfPulse}, 64'd0);
    @(negedge clk);

    // R10 long-mode overflow
    longMode = 1;
    doWrite(1, 32'h0, 32'hFFFF_FFFF);
    countEn = 1;
    @(negedge clk);
    countEn = 0;
    #1 check(ovfPulse == 1'b0, "R10 no ovf at bit31", {63'd0, ovfPulse}, 64'd0);
    readChk(1, 32'h1, 32'h0, "R10 carry into high");
    doWrite(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    countEn = 1;
    @(negedge clk);
    countEn = 0;
    #1 check(ovfPulse == 1'b1, "R10 ovf at bit63", {63'd0, ovfPulse}, 64'd1);
    readChk(1, 32'h0, 32'h0, "R10 full wrap");
    longMode = 0;

    // R11 restricted reads
    doWrite(1, 32'hCAFE, 32'hBEEF);
    userRestrict = 1; userAccessOk = 0;
    readChk(1, 32'h0, 32'h0, "R11 wide read blocked");
    readChk(0, 32'h0, 32'h0, "R11 narrow read blocked");
    userAccessOk = 1;
    readChk(1, 32'hCAFE, 32'hBEEF, "R11 read allowed");

    // R12 restricted writes
    userAccessOk = 0;
    doWrite(1, 32'h1, 32'h1);
    userAccessOk = 1;
    readChk(1, 32'hCAFE, 32'hBEEF, "R12 no access write dropped");
    userReadOnly = 1;
    doWrite(0, 32'h0, 32'h2);
    readChk(1, 32'hCAFE, 32'hBEEF, "R12 read-only write dropped");
    userReadOnly = 0;
    doWrite(0, 32'h0, 32'h3);
    readChk(1, 32'hCAFE, 32'h3, "R12 permitted write");
    userRestrict = 0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule